// File: doc/BRIEF.md
# Prescaled Interval Timer Bank

A bank of identical interval timers for the I/O space of a sound coprocessor. Each timer has an 8-bit stage that advances on prescale ticks. When the stage reaches a programmable period, it returns to zero and moves a 4-bit output counter up by one. Software sets the period through a target write port. It collects elapsed periods by reading the output counter, and that read also empties the counter.

A shared divider drives the prescale ticks from the core clock. Most timers get a slow tick. The last `NUM_FAST` timers get a faster tick. Each timer has a level enable. A rising edge on the enable restarts both stages of that timer. While the enable is low, ticks do nothing. A separate strobe clears a chosen output counter without reading it. Read data is registered and shows up one cycle after the read strobe, together with a valid flag.

Top module: `tick_timer_bank`

## Requirements
- R1: After reset all targets are 0, all stages and output counters are 0, and all enables are treated as previously low. A read of any timer after reset returns 0, and `cntRdValid` is low until the first read.
- R2: A target value N in 1..255 gives a period of N prescale ticks. A target of 0 gives a period of 256 ticks. The output counter goes up by one on the tick that brings the stage to the period, and the stage returns to 0 on that same tick.
- R3: The output counter is 4 bits wide and wraps from 15 to 0.
- R4: A read strobe with `cntRdSel` = i returns, on `cntRdData` in the next cycle with `cntRdValid` high, the value that counter i held during the strobe cycle. The counter is cleared at the same clock edge. `cntRdValid` is high only in the cycle after a read strobe.
- R5: If a read of timer i and an increment of timer i fall in the same cycle, the read returns the old value and the counter becomes 1.
- R6: The cycle in which a timer's enable is 1 and was 0 in the previous cycle clears that timer's stage and output counter. A read in that same cycle returns the value from before the restart.
- R7: While a timer's enable is 0, its stage and output counter do not advance on prescale ticks.
- R8: A counter-clear strobe with `cntWrSel` = i clears output counter i without producing read data. If an increment lands in the same cycle, the counter becomes 1.
- R9: Writing a target does not touch the stage. If the stage is already at or past the new period, the stage keeps counting, rolls over from 255 to 0 without an increment, and then counts up to the new period.
- R10: The divider counts core clocks from reset release, starting at 0. Timers 0..NUM_TIMERS-NUM_FAST-1 get a tick in cycles k*SLOW_DIV-1. The remaining timers get a tick in cycles k*FAST_DIV-1. Both divisors are powers of two, and FAST_DIV divides SLOW_DIV.
- R11: A read with `cntRdSel` >= NUM_TIMERS returns 0 and clears nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| timerEn | input | NUM_TIMERS | Level enable, one bit per timer |
| tgtWrEn | input | 1 | Target write strobe |
| tgtWrSel | input | SEL_W | Timer index for target write |
| tgtWrData | input | STAGE_W | New target value (0 means 256) |
| cntWrEn | input | 1 | Output-counter clear strobe |
| cntWrSel | input | SEL_W | Timer index for counter clear |
| cntRdEn | input | 1 | Output-counter read strobe |
| cntRdSel | input | SEL_W | Timer index for read |
| cntRdData | output | CNT_W | Registered read data |
| cntRdValid | output | 1 | High one cycle after a read strobe |

## Verification
The assertions assume that the read, clear and target strobes are single-cycle pulses sampled at the rising edge. They also assume that inputs are held low through reset, so their history at reset release is defined. The bench drives every input on the falling edge, keeps all strobes low while reset is active, and issues back-to-back reads only through a burst that holds the same selector. The enable-restart property checks a read one cycle after a rising edge. The bench creates exactly that case, and also the case where the read falls in the rising-edge cycle itself.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;

  // Per-lane strobes from control to datapath
  typedef struct packed {
    logic tick;     // prescale tick reaching an enabled lane
    logic restart;  // enable rising edge: clear stage and counter
    logic rdPick;   // lane selected by a read (clear + mux)
    logic wrClr;    // lane selected by a counter-clear strobe
    logic loadTgt;  // lane selected by a target write
  } laneCtl_t;

endpackage

// File: rtl/tick_divider.sv
module tick_divider #(
  parameter int SLOW_DIV = 128,
  parameter int FAST_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  output logic slowTick,
  output logic fastTick
);
  localparam int DIV_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [DIV_W-1:0] SLOW_LAST = DIV_W'(SLOW_DIV - 1);
  localparam logic [DIV_W-1:0] FAST_MASK = DIV_W'(FAST_DIV - 1);

  logic [DIV_W-1:0] divCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) divCnt <= '0;
    else if (divCnt == SLOW_LAST) divCnt <= '0;
    else divCnt <= divCnt + 1'b1;
  end

  // Power-of-two divisors: the fast tick is the low bits all ones
  assign slowTick = (divCnt == SLOW_LAST);
  assign fastTick = ((divCnt & FAST_MASK) == FAST_MASK);
endmodule

// File: rtl/tick_timer_ctrl.sv
module tick_timer_ctrl
  import tick_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_FAST   = 1,
  parameter int SEL_W      = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  slowTick,
  input  logic                  fastTick,
  input  logic [NUM_TIMERS-1:0] timerEn,
  input  logic                  tgtWrEn,
  input  logic [SEL_W-1:0]      tgtWrSel,
  input  logic                  cntWrEn,
  input  logic [SEL_W-1:0]      cntWrSel,
  input  logic                  cntRdEn,
  input  logic [SEL_W-1:0]      cntRdSel,
  output laneCtl_t [NUM_TIMERS-1:0] laneCtl,
  output logic                  rdStrobe
);
  localparam int FIRST_FAST = NUM_TIMERS - NUM_FAST;

  logic [NUM_TIMERS-1:0] enQ;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) enQ <= '0;
    else enQ <= timerEn;
  end

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_ctl
    logic laneTick;
    if (i >= FIRST_FAST) begin : g_fast
      assign laneTick = fastTick;
    end else begin : g_slow
      assign laneTick = slowTick;
    end
    assign laneCtl[i].tick    = timerEn[i] & laneTick;
    assign laneCtl[i].restart = timerEn[i] & ~enQ[i];
    assign laneCtl[i].rdPick  = cntRdEn & (cntRdSel == SEL_W'(i));
    assign laneCtl[i].wrClr   = cntWrEn & (cntWrSel == SEL_W'(i));
    assign laneCtl[i].loadTgt = tgtWrEn & (tgtWrSel == SEL_W'(i));
  end

  assign rdStrobe = cntRdEn;
endmodule

// File: rtl/tick_timer_datapath.sv
module tick_timer_datapath
  import tick_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int STAGE_W    = 8,
  parameter int CNT_W      = 4
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  laneCtl_t [NUM_TIMERS-1:0] laneCtl,
  input  logic [STAGE_W-1:0]        tgtWrData,
  input  logic                      rdStrobe,
  output logic [CNT_W-1:0]          cntRdData,
  output logic                      cntRdValid
);
  localparam logic [STAGE_W:0] FULL_PERIOD = {1'b1, {STAGE_W{1'b0}}};

  logic [CNT_W-1:0] cntArr [NUM_TIMERS];
  logic [CNT_W-1:0] rdMux;

  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_lane
    logic [STAGE_W-1:0] tgtQ;
    logic [STAGE_W-1:0] stageQ;
    logic [CNT_W-1:0]   cntQ;
    logic [STAGE_W:0]   periodLen;
    logic [STAGE_W:0]   stageNext;
    logic               wrapHit;
    logic               anyClr;

    // Target 0 stands for the full 2^STAGE_W period
    assign periodLen = (tgtQ == '0) ? FULL_PERIOD : {1'b0, tgtQ};
    assign stageNext = {1'b0, stageQ} + (STAGE_W+1)'(1);
    assign wrapHit   = laneCtl[i].tick & (stageNext == periodLen);
    assign anyClr    = laneCtl[i].rdPick | laneCtl[i].wrClr;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) tgtQ <= '0;
      else if (laneCtl[i].loadTgt) tgtQ <= tgtWrData;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stageQ <= '0;
        cntQ   <= '0;
      end else if (laneCtl[i].restart) begin
        stageQ <= '0;
        cntQ   <= '0;
      end else begin
        if (laneCtl[i].tick)
          stageQ <= wrapHit ? '0 : stageNext[STAGE_W-1:0];
        if (anyClr)
          cntQ <= wrapHit ? CNT_W'(1) : '0;
        else if (wrapHit)
          cntQ <= cntQ + 1'b1;
      end
    end

    assign cntArr[i] = cntQ;
  end

  always_comb begin
    rdMux = '0;
    for (int k = 0; k < NUM_TIMERS; k++)
      if (laneCtl[k].rdPick) rdMux = rdMux | cntArr[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cntRdData  <= '0;
      cntRdValid <= 1'b0;
    end else begin
      cntRdValid <= rdStrobe;
      if (rdStrobe) cntRdData <= rdMux;
    end
  end
endmodule

// File: rtl/tick_timer_bank.sv
module tick_timer_bank
  import tick_timer_pkg::*;
#(
  parameter int NUM_TIMERS = 3,
  parameter int NUM_FAST   = 1,
  parameter int STAGE_W    = 8,
  parameter int CNT_W      = 4,
  parameter int SLOW_DIV   = 128,
  parameter int FAST_DIV   = 16,
  parameter int SEL_W      = (NUM_TIMERS > 1) ? $clog2(NUM_TIMERS + 1) : 1
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_TIMERS-1:0] timerEn,
  input  logic                  tgtWrEn,
  input  logic [SEL_W-1:0]      tgtWrSel,
  input  logic [STAGE_W-1:0]    tgtWrData,
  input  logic                  cntWrEn,
  input  logic [SEL_W-1:0]      cntWrSel,
  input  logic                  cntRdEn,
  input  logic [SEL_W-1:0]      cntRdSel,
  output logic [CNT_W-1:0]      cntRdData,
  output logic                  cntRdValid
);
  logic slowTick;
  logic fastTick;
  logic rdStrobe;
  laneCtl_t [NUM_TIMERS-1:0] laneCtl;

  tick_divider #(
    .SLOW_DIV(SLOW_DIV),
    .FAST_DIV(FAST_DIV)
  ) u_div (
    .clk(clk),
    .rst_n(rst_n),
    .slowTick(slowTick),
    .fastTick(fastTick)
  );

  tick_timer_ctrl #(
    .NUM_TIMERS(NUM_TIMERS),
    .NUM_FAST(NUM_FAST),
    .SEL_W(SEL_W)
  ) u_ctrl (
    .clk(clk),
    .rst_n(rst_n),
    .slowTick(slowTick),
    .fastTick(fastTick),
    .timerEn(timerEn),
    .tgtWrEn(tgtWrEn),
    .tgtWrSel(tgtWrSel),
    .cntWrEn(cntWrEn),
    .cntWrSel(cntWrSel),
    .cntRdEn(cntRdEn),
    .cntRdSel(cntRdSel),
    .laneCtl(laneCtl),
    .rdStrobe(rdStrobe)
  );

  tick_timer_datapath #(
    .NUM_TIMERS(NUM_TIMERS),
    .STAGE_W(STAGE_W),
    .CNT_W(CNT_W)
  ) u_dp (
    .clk(clk),
    .rst_n(rst_n),
    .laneCtl(laneCtl),
    .tgtWrData(tgtWrData),
    .rdStrobe(rdStrobe),
    .cntRdData(cntRdData),
    .cntRdValid(cntRdValid)
  );
endmodule

// File: rtl/tick_timer_bank_chk.sv
module tick_timer_bank_chk #(
  parameter int NUM_TIMERS = 3,
  parameter int SEL_W      = 2,
  parameter int CNT_W      = 4,
  parameter int SLOW_DIV   = 128,
  parameter int FAST_DIV   = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_TIMERS-1:0] timerEn,
  input logic                  cntRdEn,
  input logic [SEL_W-1:0]      cntRdSel,
  input logic [CNT_W-1:0]      cntRdData,
  input logic                  cntRdValid,
  input logic                  slowTick,
  input logic                  fastTick
);
  // R4: read data qualifier follows the read strobe by one cycle
  assert_rd_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    cntRdEn |=> cntRdValid);
  assert_no_stray_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cntRdEn |=> !cntRdValid);

  // R11: unmapped selector reads as zero
  assert_oob_zero_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cntRdEn && (int'(cntRdSel) >= NUM_TIMERS)) |=> (cntRdData == '0));

  // R5: a second read right after the first sees at most one new increment
  assert_reread_small_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cntRdEn && $past(cntRdEn) && (cntRdSel == $past(cntRdSel)))
      |=> (cntRdData <= CNT_W'(1)));

  // R10: fast and slow ticks are aligned single-cycle pulses
  assert_slow_in_fast_R10: assert property (@(posedge clk) disable iff (!rst_n)
    slowTick |-> fastTick);
  if (SLOW_DIV > 1) begin : g_slow_gap
    assert_slow_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      slowTick |=> !slowTick);
  end
  if (FAST_DIV > 1) begin : g_fast_gap
    assert_fast_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
      fastTick |=> !fastTick);
  end

  // R6: a read one cycle after an enable rise sees the restarted counter
  for (genvar i = 0; i < NUM_TIMERS; i++) begin : g_lane_chk
    assert_restart_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(timerEn[i]) && !$past(timerEn[i], 2) && cntRdEn &&
       (cntRdSel == SEL_W'(i))) |=> (cntRdData == '0));
  end
endmodule

bind tick_timer_bank tick_timer_bank_chk #(
  .NUM_TIMERS(NUM_TIMERS),
  .SEL_W(SEL_W),
  .CNT_W(CNT_W),
  .SLOW_DIV(SLOW_DIV),
  .FAST_DIV(FAST_DIV)
) u_chk (
  .clk(clk),
  .rst_n(rst_n),
  .timerEn(timerEn),
  .cntRdEn(cntRdEn),
  .cntRdSel(cntRdSel),
  .cntRdData(cntRdData),
  .cntRdValid(cntRdValid),
  .slowTick(slowTick),
  .fastTick(fastTick)
);

// File: tb/tick_timer_bank_tb.sv
`timescale 1ns/1ps
module tick_timer_bank_tb;
  localparam int NT   = 3;
  localparam int SLOW = 16;
  localparam int FAST = 4;
  localparam int SW   = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [NT-1:0] timerEn = '0;
  logic          tgtWrEn = 1'b0;
  logic [SW-1:0] tgtWrSel = '0;
  logic [7:0]    tgtWrData = '0;
  logic          cntWrEn = 1'b0;
  logic [SW-1:0] cntWrSel = '0;
  logic          cntRdEn = 1'b0;
  logic [SW-1:0] cntRdSel = '0;
  logic [3:0]    cntRdData;
  logic          cntRdValid;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;  // 250 MHz

  tick_timer_bank #(
    .NUM_TIMERS(NT), .NUM_FAST(1), .STAGE_W(8), .CNT_W(4),
    .SLOW_DIV(SLOW), .FAST_DIV(FAST), .SEL_W(SW)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .timerEn(timerEn),
    .tgtWrEn(tgtWrEn), .tgtWrSel(tgtWrSel), .tgtWrData(tgtWrData),
    .cntWrEn(cntWrEn), .cntWrSel(cntWrSel),
    .cntRdEn(cntRdEn), .cntRdSel(cntRdSel),
    .cntRdData(cntRdData), .cntRdValid(cntRdValid)
  );

  // Behavioural model of the requirements (R2, R3, R5-R10)
  int mStage [NT];
  int mCnt   [NT];
  int mTgt   [NT];
  bit mEnQ   [NT];
  int cyc;

  always @(posedge clk) begin
    if (!rst_n) begin
      cyc = 0;
      for (int i = 0; i < NT; i++) begin
        mStage[i] = 0; mCnt[i] = 0; mTgt[i] = 0; mEnQ[i] = 0;
      end
    end else begin
      bit slowT, fastT;
      slowT = (cyc % SLOW) == SLOW - 1;
      fastT = (cyc % FAST) == FAST - 1;
      for (int i = 0; i < NT; i++) begin
        bit tk, inc, clr;
        int per;
        per = (mTgt[i] == 0) ? 256 : mTgt[i];
        tk  = timerEn[i] && ((i == NT - 1) ? fastT : slowT);
        inc = 0;
        if (timerEn[i] && !mEnQ[i]) begin
          mStage[i] = 0; mCnt[i] = 0;
        end else begin
          if (tk) begin
            if (mStage[i] + 1 == per) begin mStage[i] = 0; inc = 1; end
            else mStage[i] = (mStage[i] + 1) % 256;
          end
          clr = (cntRdEn && int'(cntRdSel) == i) || (cntWrEn && int'(cntWrSel) == i);
          if (clr) mCnt[i] = inc ? 1 : 0;
          else if (inc) mCnt[i] = (mCnt[i] + 1) % 16;
        end
        if (tgtWrEn && int'(tgtWrSel) == i) mTgt[i] = int'(tgtWrData);
        mEnQ[i] = timerEn[i];
      end
      cyc++;
    end
  end

  // Scoreboard
  int    expQ [$];
  string tagQ [$];

  always @(negedge clk) begin
    if (rst_n && cntRdValid) begin
      checks++;
      if (expQ.size() == 0) begin
        errors++;
        $display("FAIL R4: read data valid with no read pending (act %0d, exp none)", cntRdData);
      end else begin
        int e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        if (int'(cntRdData) != e) begin
          errors++;
          $display("FAIL %s: counter read act %0d exp %0d at t=%0t", t, cntRdData, e, $time);
        end
      end
    end
  end

  // Driver tasks: entered and left on a falling edge
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeTgt(input int sel, input int val);
    tgtWrEn = 1'b1; tgtWrSel = SW'(sel); tgtWrData = 8'(val);
    @(negedge clk);
    tgtWrEn = 1'b0;
  endtask

  task automatic clearCnt(input int sel);
    cntWrEn = 1'b1; cntWrSel = SW'(sel);
    @(negedge clk);
    cntWrEn = 1'b0;
  endtask

  task automatic readBurst(input int sel, input int n, input string tag);
    for (int k = 0; k < n; k++) begin
      cntRdEn = 1'b1; cntRdSel = SW'(sel);
      expQ.push_back((sel < NT) ? mCnt[sel] : 0);
      tagQ.push_back(tag);
      @(negedge clk);
    end
    cntRdEn = 1'b0;
  endtask

  task automatic readCnt(input int sel, input string tag);
    readBurst(sel, 1, tag);
  endtask

  task automatic finishRun();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  // Watchdog
  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete (act timeout, exp finish)");
    finishRun();
  end

  initial begin
    idle(4);
    rst_n = 1'b1;
    // R1: reset state on the outputs
    checks++;
    if (cntRdValid !== 1'b0 || cntRdData !== 4'd0) begin
      errors++;
      $display("FAIL R1: reset outputs act %0d/%0d exp 0/0", cntRdValid, cntRdData);
    end
    readCnt(0, "R1"); readCnt(1, "R1"); readCnt(2, "R1");
    readCnt(3, "R11");

    // R2: period of 3 on a slow timer
    writeTgt(0, 3);
    timerEn[0] = 1'b1;
    idle(SLOW * 3 * 2 + 5);
    readCnt(0, "R2");
    readCnt(0, "R4");

    // R10: period 1 shows the slow and fast tick rates
    writeTgt(0, 1);
    idle(SLOW * 5);
    readCnt(0, "R10");
    writeTgt(2, 1);
    timerEn[2] = 1'b1;
    idle(FAST * 5 + 1);
    readCnt(2, "R10");

    // R3: wrap of the output counter
    idle(FAST * 18);
    readCnt(2, "R3");

    // R5: reads every cycle, some coincide with increments
    readBurst(2, 12, "R5");

    // R8: counter clear strobe
    idle(FAST * 3);
    clearCnt(2);
    readCnt(2, "R8");
    idle(FAST * 3 + 1);
    clearCnt(2);
    idle(FAST * 2 - 1);
    clearCnt(2);
    readCnt(2, "R8");

    // R7: never-enabled timer and a disabled timer ignore ticks
    writeTgt(1, 1);
    idle(SLOW * 3);
    readCnt(1, "R7");
    timerEn[2] = 1'b0;
    readCnt(2, "R7");
    idle(FAST * 10);
    readCnt(2, "R7");

    // R6: restart on an enable rise
    idle(SLOW * 3);
    timerEn[0] = 1'b0;
    idle(3);
    timerEn[0] = 1'b1;
    readCnt(0, "R6");
    readCnt(0, "R6");
    idle(SLOW * 2);
    readCnt(0, "R6");

    // R2: target 0 means 256 ticks
    timerEn[2] = 1'b1;
    writeTgt(2, 0);
    readCnt(2, "R2");
    idle(FAST * 255);
    readCnt(2, "R2");
    idle(FAST * 257 + 3);
    readCnt(2, "R2");

    // R9: lowering the target below the stage rolls through 256
    timerEn[2] = 1'b0;
    writeTgt(2, 200);
    timerEn[2] = 1'b1;
    idle(FAST * 10);
    writeTgt(2, 5);
    idle(FAST * 50);
    readCnt(2, "R9");
    idle(FAST * 200);
    readCnt(2, "R9");
    // R9: raising the target above the stage keeps the stage
    writeTgt(2, 40);
    idle(FAST * 10);
    writeTgt(2, 30);
    idle(FAST * 25);
    readCnt(2, "R9");

    idle(4);
    if (expQ.size() != 0) begin
      errors++;
      $display("FAIL R4: %0d reads without data (act missing, exp 0)", expQ.size());
    end
    finishRun();
  end
endmodule